// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds the register file of a stack-organised floating-point unit: eight 80-bit registers arranged in a ring. A small pointer names the physical register that is currently the top of the stack. Pushing and popping only move that pointer, so no register contents are ever copied. An external arithmetic unit reads its two operands through the block and hands its result back through the same operation interface.

Four operations exist.
- Push stores a loaded value into a fresh top entry.
- Pop discards the top.
- Replace-top overwrites the top entry with a result.
- Write-and-pop stores a result one entry below the top and then pops, so the result becomes the new top.

Operands are addressed relative to the top: entry i of the stack lives in physical register (top + i) mod 8. A reverse flag swaps the two operand ports, for non-commutative work such as reversed division. Each register carries a valid tag, and two sticky flags report pushes onto live entries and reads of empty entries. A debug port reads any physical register directly, including those already vacated by a pop.

Top module: `fstack_ring`

## Requirements
- R1: After synchronous reset, top_ptr is 0, tag_vec is all zero, and ovf and unf are low.
- R2: Operation code 1 (push) writes wr_data into physical register (top_ptr - 1) mod 8 and moves top_ptr there in the same clock. The pointer wraps from 0 to 7.
- R3: Operation code 2 (pop) increments top_ptr mod 8, wrapping from 7 to 0. The vacated register keeps its contents, and dbg_data returns them when dbg_idx selects it.
- R4: With rev low, opa shows stack entry 0, which is physical register top_ptr, and opb shows stack entry src_idx, which is physical register (top_ptr + src_idx) mod 8.
- R5: With rev high, the two operand ports swap: opa shows stack entry src_idx and opb shows stack entry 0.
- R6: Operation code 3 (replace-top) writes wr_data into stack entry 0 and sets its tag, and top_ptr does not change.
- R7: Operation code 4 (write-and-pop) writes wr_data into stack entry 1, sets that tag, clears the tag of the old top, and increments top_ptr. Afterwards opa (with rev low) shows wr_data.
- R8: Bit k of tag_vec is the valid tag of physical register k. A push or replace-top sets the tag of the register written, and a pop clears the tag of the vacated register.
- R9: A push whose target register already has its tag set raises ovf. The push still writes. The ovf flag stays high until reset.
- R10: unf rises and stays high until reset when either of these happens:
  - opnd_rd is high while the tag of stack entry 0 or of stack entry src_idx is clear;
  - a pop or write-and-pop is issued while the tag of stack entry 0 is clear.
- R11: Operation codes 0, 5, 6 and 7 change no register, tag or pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code: 0 idle, 1 push, 2 pop, 3 replace-top, 4 write-and-pop, 5..7 idle |
| wr_data | input | 80 | Value to push or result to write |
| opnd_rd | input | 1 | High when the arithmetic unit consumes the operands this cycle |
| src_idx | input | 3 | Stack-relative index i of the second operand |
| rev | input | 1 | Swap the operand ports |
| dbg_idx | input | 3 | Physical register to read on the debug port |
| opa | output | 80 | First operand |
| opb | output | 80 | Second operand |
| dbg_data | output | 80 | Contents of physical register dbg_idx |
| top_ptr | output | 3 | Physical index of the stack top |
| tag_vec | output | 8 | Valid tag of each physical register |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that op is a known 3-bit code on every clock edge outside reset. They also assume the register count is a power of two, so that pointer arithmetic wraps naturally. The stimulus drives every input, including the idle and unused codes, on each falling edge, and never leaves an input unknown once reset is released. A directed phase walks the pointer across both wrap points before a pseudo-random phase mixes all operation codes, operand indices and the reverse flag.

// File: rtl/fstack_pkg.sv
package fstack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_REPL  = 3'd3,
    OP_WRPOP = 3'd4
  } stk_op_e;
endpackage

// File: rtl/fstack_ctrl.sv
// Pointer, tag and flag control for the ring stack.
module fstack_ctrl
  import fstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic             opnd_rd,
  input  logic [PW-1:0]    src_idx,
  output logic [PW-1:0]    top,
  output logic [DEPTH-1:0] tags,
  output logic             ovf,
  output logic             unf,
  output logic             wr_en,
  output logic [PW-1:0]    wr_addr,
  output logic [PW-1:0]    sti_addr
);
  localparam logic [PW-1:0]    ONE  = PW'(1);
  localparam logic [DEPTH-1:0] BIT0 = DEPTH'(1);

  logic [PW-1:0]    top_up, top_dn;
  logic [DEPTH-1:0] set_vec, clr_vec;
  logic             is_push, is_pop, is_repl, is_wrpop;
  logic             ovf_hit, unf_hit;

  always_comb begin
    is_push  = (op == OP_PUSH);
    is_pop   = (op == OP_POP);
    is_repl  = (op == OP_REPL);
    is_wrpop = (op == OP_WRPOP);
    top_up   = top + ONE;
    top_dn   = top - ONE;
    sti_addr = top + src_idx;
    wr_en    = is_push | is_repl | is_wrpop;
    if (is_push)       wr_addr = top_dn;
    else if (is_wrpop) wr_addr = top_up;
    else               wr_addr = top;
    set_vec  = wr_en ? (BIT0 << wr_addr) : '0;
    clr_vec  = (is_pop | is_wrpop) ? (BIT0 << top) : '0;
    ovf_hit  = is_push & tags[top_dn];
    unf_hit  = (opnd_rd & (~tags[top] | ~tags[sti_addr]))
             | ((is_pop | is_wrpop) & ~tags[top]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (is_push)                 top <= top_dn;
      else if (is_pop | is_wrpop)  top <= top_up;
      if (ovf_hit) ovf <= 1'b1;
      if (unf_hit) unf <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst)             tags[g] <= 1'b0;
      else if (set_vec[g]) tags[g] <= 1'b1;
      else if (clr_vec[g]) tags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fstack_regfile.sv
// One write port, three asynchronous read ports; no reset so it maps to distributed RAM.
module fstack_regfile #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    ra0,
  input  logic [PW-1:0]    ra1,
  input  logic [PW-1:0]    ra2,
  output logic [WIDTH-1:0] rd0,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
endmodule

// File: rtl/fstack_opsel.sv
// Operand ordering for the arithmetic unit.
module fstack_opsel #(
  parameter int WIDTH = 80
) (
  input  logic             rev,
  input  logic [WIDTH-1:0] st0,
  input  logic [WIDTH-1:0] sti,
  output logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] b
);
  always_comb begin
    if (rev) begin
      a = sti;
      b = st0;
    end else begin
      a = st0;
      b = sti;
    end
  end
endmodule

// File: rtl/fstack_ring.sv
module fstack_ring #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             opnd_rd,
  input  logic [PW-1:0]    src_idx,
  input  logic             rev,
  input  logic [PW-1:0]    dbg_idx,
  output logic [WIDTH-1:0] opa,
  output logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] dbg_data,
  output logic [PW-1:0]    top_ptr,
  output logic [DEPTH-1:0] tag_vec,
  output logic             ovf,
  output logic             unf
);
  logic             wr_en;
  logic [PW-1:0]    wr_addr, sti_addr;
  logic [WIDTH-1:0] st0_q, sti_q;

  fstack_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .op(op), .opnd_rd(opnd_rd), .src_idx(src_idx),
    .top(top_ptr), .tags(tag_vec), .ovf(ovf), .unf(unf),
    .wr_en(wr_en), .wr_addr(wr_addr), .sti_addr(sti_addr)
  );

  fstack_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_rf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .ra0(top_ptr), .ra1(sti_addr), .ra2(dbg_idx),
    .rd0(st0_q), .rd1(sti_q), .rd2(dbg_data)
  );

  fstack_opsel #(.WIDTH(WIDTH)) u_sel (
    .rev(rev), .st0(st0_q), .sti(sti_q), .a(opa), .b(opb)
  );
endmodule

// File: rtl/fstack_ring_chk.sv
module fstack_ring_chk
  import fstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op,
  input logic [PW-1:0]    top,
  input logic [DEPTH-1:0] tags,
  input logic             ovf,
  input logic             unf
);
  localparam logic [PW-1:0] ONE = PW'(1);

  p_push_dec_r2: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> top == $past(top) - ONE);

  p_pop_inc_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> top == $past(top) + ONE);

  p_repl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    op == OP_REPL |=> top == $past(top) && tags[top]);

  p_wrpop_top_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_WRPOP |=> top == $past(top) + ONE && tags[top]);

  p_push_tag_r8: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> tags[top]);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    op > 3'd4 || op == 3'd0 |=> $stable(top) && $stable(tags));
endmodule

bind fstack_ring fstack_ring_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .top(top_ptr), .tags(tag_vec),
  .ovf(ovf), .unf(unf)
);

// File: tb/fstack_ring_bench.sv
`timescale 1ns/1ps
module fstack_ring_bench;
  localparam int N = 8;
  localparam int W = 80;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op = '0;
  logic [W-1:0] wr_data = '0;
  logic         opnd_rd = 1'b0;
  logic [2:0]   src_idx = '0;
  logic         rev = 1'b0;
  logic [2:0]   dbg_idx = '0;
  logic [W-1:0] opa, opb, dbg_data;
  logic [2:0]   top_ptr;
  logic [N-1:0] tag_vec;
  logic         ovf, unf;

  always #4 clk = ~clk;

  fstack_ring u_fstack_ring (
    .clk(clk), .rst(rst), .op(op), .wr_data(wr_data), .opnd_rd(opnd_rd),
    .src_idx(src_idx), .rev(rev), .dbg_idx(dbg_idx), .opa(opa), .opb(opb),
    .dbg_data(dbg_data), .top_ptr(top_ptr), .tag_vec(tag_vec), .ovf(ovf), .unf(unf)
  );

  // behavioural reference
  logic [W-1:0] m_mem [N];
  bit           m_wr [N];
  bit           m_tag [N];
  int           m_top;
  bit           m_ovf, m_unf;
  int           checks = 0, errors = 0;
  bit           done = 0;
  logic [31:0]  seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_tagvec();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = m_tag[k];
    return v;
  endfunction

  task automatic model_reset();
    m_top = 0; m_ovf = 0; m_unf = 0;
    for (int k = 0; k < N; k++) begin m_tag[k] = 0; m_wr[k] = 0; end
  endtask

  // compare all outputs against the model pre-state for the driven inputs
  task automatic compare(input string ph);
    int si;
    logic [W-1:0] e0, ei;
    si = (m_top + int'(src_idx)) % N;
    chk(top_ptr == 3'(m_top), {ph, " R2 top_ptr"}, W'(top_ptr), W'(m_top));
    chk(tag_vec == m_tagvec(), {ph, " R8 tag_vec"}, W'(tag_vec), W'(m_tagvec()));
    chk(ovf == m_ovf, {ph, " R9 ovf"}, W'(ovf), W'(m_ovf));
    chk(unf == m_unf, {ph, " R10 unf"}, W'(unf), W'(m_unf));
    e0 = m_mem[m_top];
    ei = m_mem[si];
    if (m_wr[m_top] && m_wr[si]) begin
      if (!rev) begin
        chk(opa == e0, {ph, " R4 opa"}, opa, e0);
        chk(opb == ei, {ph, " R4 opb"}, opb, ei);
      end else begin
        chk(opa == ei, {ph, " R5 opa"}, opa, ei);
        chk(opb == e0, {ph, " R5 opb"}, opb, e0);
      end
    end
    if (m_wr[dbg_idx])
      chk(dbg_data == m_mem[dbg_idx], {ph, " R3 dbg_data"}, dbg_data, m_mem[dbg_idx]);
  endtask

  task automatic model_step();
    int t, n, si;
    si = (m_top + int'(src_idx)) % N;
    if (opnd_rd && (!m_tag[m_top] || !m_tag[si])) m_unf = 1;
    case (op)
      3'd1: begin
        t = (m_top + N - 1) % N;
        if (m_tag[t]) m_ovf = 1;
        m_mem[t] = wr_data; m_wr[t] = 1; m_tag[t] = 1; m_top = t;
      end
      3'd2: begin
        if (!m_tag[m_top]) m_unf = 1;
        m_tag[m_top] = 0; m_top = (m_top + 1) % N;
      end
      3'd3: begin
        m_mem[m_top] = wr_data; m_wr[m_top] = 1; m_tag[m_top] = 1;
      end
      3'd4: begin
        n = (m_top + 1) % N;
        if (!m_tag[m_top]) m_unf = 1;
        m_mem[n] = wr_data; m_wr[n] = 1; m_tag[n] = 1;
        m_tag[m_top] = 0; m_top = n;
      end
      default: ;
    endcase
  endtask

  task automatic step(input logic [2:0] o, input logic [W-1:0] d, input logic [2:0] s,
                      input logic rv, input logic rd, input logic [2:0] dbg,
                      input string ph);
    @(negedge clk);
    op = o; wr_data = d; src_idx = s; rev = rv; opnd_rd = rd; dbg_idx = dbg;
    #1;
    compare(ph);
    model_step();
  endtask

  function automatic logic [W-1:0] val(input int k);
    return {16'hC0DE, 32'(k * 32'h9E37_79B9), 32'(k + 1)};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(top_ptr == 3'd0, "R1 top after reset", W'(top_ptr), 0);
    chk(tag_vec == '0, "R1 tags after reset", W'(tag_vec), 0);
    chk(!ovf && !unf, "R1 flags after reset", W'({ovf, unf}), 0);
    rst = 1'b0;

    // R2: fill all eight, pointer wraps 0 -> 7 first
    for (int k = 0; k < 8; k++) step(3'd1, val(k), 3'd1, 1'b0, 1'b0, 3'(k), "R2");
    step(3'd0, '0, 3'd3, 1'b0, 1'b1, 3'd7, "R2");
    chk(top_ptr == 3'd0 && opa == val(7), "R2 top after 8 pushes", W'(top_ptr), 0);
    // R5: reversed operands
    step(3'd0, '0, 3'd2, 1'b1, 1'b1, 3'd0, "R5");
    chk(opa == val(5) && opb == val(7), "R5 reversed pair", opa, val(5));
    // R9: ninth push overflows
    step(3'd1, val(8), 3'd0, 1'b0, 1'b0, 3'd7, "R9");
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd7, "R9");
    chk(ovf == 1'b1, "R9 ovf after ninth push", W'(ovf), 1);
    // R6: replace top
    step(3'd3, val(40), 3'd1, 1'b0, 1'b0, 3'd7, "R6");
    step(3'd0, '0, 3'd1, 1'b0, 1'b0, 3'd7, "R6");
    chk(top_ptr == 3'd7 && opa == val(40), "R6 replace keeps pointer", opa, val(40));
    // R3: pop wraps 7 -> 0; vacated data stays readable
    step(3'd2, '0, 3'd0, 1'b0, 1'b0, 3'd7, "R3");
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd7, "R3");
    chk(top_ptr == 3'd0 && dbg_data == val(40) && !tag_vec[7], "R3 vacated kept",
        dbg_data, val(40));
    // R7: write-and-pop
    step(3'd4, val(50), 3'd1, 1'b0, 1'b1, 3'd0, "R7");
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd0, "R7");
    chk(top_ptr == 3'd1 && opa == val(50) && !tag_vec[0], "R7 result on top",
        opa, val(50));
    // R11: unused codes
    for (int c = 5; c < 8; c++) step(3'(c), val(60 + c), 3'd0, 1'b0, 1'b0, 3'd1, "R11");
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd1, "R11");
    chk(top_ptr == 3'd1 && opa == val(50), "R11 unused codes ignored", opa, val(50));
    // R10: drain and pop past empty
    for (int k = 0; k < 8; k++) step(3'd2, '0, 3'd0, 1'b0, 1'b0, 3'd0, "R10");
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd0, "R10");
    chk(unf == 1'b1, "R10 unf after popping empty", W'(unf), 1);

    // reset again, then mixed traffic
    @(negedge clk); rst = 1'b1; op = '0; opnd_rd = 1'b0;
    @(negedge clk); model_reset(); rst = 1'b0;
    #1;
    chk(top_ptr == 3'd0 && tag_vec == '0 && !ovf && !unf, "R1 second reset", W'(top_ptr), 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      seed = nxt(seed); r = seed;
      step((r[2:0] == 3'd2 && k < 100) ? 3'd1 : r[2:0], {r, ~r, r[15:0]}, r[5:3],
           r[6], (k > 200) ? r[7] : 1'b0, r[10:8], "mix");
    end
    step(3'd0, '0, 3'd0, 1'b0, 1'b0, 3'd0, "final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule